// File: doc/BRIEF.md
# Sticky Fault-to-Break Lock Register

This block holds one configuration word of set-once enable bits. Each enable bit connects one fault source to a single break output. That break output stops the power-stage timers elsewhere in the chip. There are eleven fault sources:

- double-bit ECC error flags from seven on-chip RAM regions, from backup RAM and from flash;
- a processor lockup signal;
- a supply-voltage monitor output.

Software sets an enable bit by writing a one to it at the register offset. A written zero never clears a bit; only the asynchronous system reset does. So once software connects a fault path, that path stays connected until the next reset.

The break output is the OR of every enabled fault, registered once so that it is free of glitches. It follows the fault levels and does not hold a fault on its own. The enable bit of the voltage monitor is also exported as a lock signal. The power-control block uses it to refuse writes to its monitor enable and its 3-bit threshold field.

Top module: `fault_brk_lock`

## Requirements
- R1: After reset, every enable bit reads 0, `brk_o` is 0 and `pvm_lock_o` is 0.
- R2: The fault inputs map to register bits as follows. The position of each source's enable bit matters to software.

  | fault_i bit | Source | Register bit |
  |---|---|---|
  | 0 | AXI SRAM ECC | 15 |
  | 1 | ITCM ECC | 14 |
  | 2 | DTCM ECC | 13 |
  | 3 | SRAM1 ECC | 12 |
  | 4 | SRAM2 ECC | 11 |
  | 5 | SRAM3 ECC | 10 |
  | 6 | SRAM4 ECC | 9 |
  | 7 | backup RAM ECC | 7 |
  | 8 | processor lockup | 6 |
  | 9 | flash ECC | 3 |
  | 10 | voltage monitor | 2 |

- R3: A write at offset 0x018 sets each enable bit whose data bit is 1. The new value is visible from the next clock edge.
- R4: Writing 0 to a set bit leaves it set. Only reset clears it.
- R5: Reserved bits (31:16, 8, 5:4, 1:0; writable mask 0x0000FECC) read as zero, and writes to them have no effect.
- R6: A write at any other offset changes no bit, and a read at any other offset returns 0.
- R7: `brk_o` is high one cycle after any fault input whose enable bit is set is high. Faults whose enable bit is clear have no effect.
- R8: `brk_o` does not latch. It returns low one cycle after every enabled fault goes low.
- R9: `pvm_lock_o` is high exactly while the voltage-monitor bit (bit 2) is set.
- R10: A read at offset 0x018 returns the current enable bits in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i |
| fault_i | input | 11 | Level fault sources, in the order of R2 |
| brk_o | output | 1 | Registered break request |
| pvm_lock_o | output | 1 | Freezes the voltage-monitor configuration |

## Verification
The assertions take it that the fault inputs are synchronous levels, sampled only at the clock edge. They also take it that the write strobe, address and data are stable around that edge, and that no write is attempted during reset.

The stimulus changes every input one time unit after a falling edge. It holds each value for a full cycle, and it applies reset only while no expected item is waiting. Because of this, each scoreboard item can be compared at a fixed falling edge.

// File: rtl/brk_lock_pkg.sv
package brk_lock_pkg;
  localparam int NUM_SRC = 11;
  localparam int PVM_IDX = 10;

  // source index -> bit position in the lock word
  function automatic int src_pos(input int idx);
    case (idx)
      0: return 15;
      1: return 14;
      2: return 13;
      3: return 12;
      4: return 11;
      5: return 10;
      6: return 9;
      7: return 7;
      8: return 6;
      9: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [31:0] wr_mask();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[src_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/brk_lock_regs.sv
module brk_lock_regs
  import brk_lock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h018
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_SRC-1:0] lock_o
);
  logic hit_we;
  assign hit_we = we_i && (addr_i == REG_OFS);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    localparam int P = src_pos(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    lock_o[i] <= 1'b0;
      else if (hit_we && wdata_i[P])  lock_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/brk_lock_rd.sv
module brk_lock_rd
  import brk_lock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h018
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] lock_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_SRC; i++) word[src_pos(i)] = lock_i[i];
  end

  assign rdata_o = (addr_i == REG_OFS) ? word : '0;
endmodule

// File: rtl/brk_fault_merge.sv
module brk_fault_merge
  import brk_lock_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] fault_i,
  input  logic [NUM_SRC-1:0] lock_i,
  output logic               brk_o
);
  logic brk_d;
  assign brk_d = |(fault_i & lock_i);

  // single flop keeps the break line glitch free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_o <= 1'b0;
    else         brk_o <= brk_d;
  end
endmodule

// File: rtl/fault_brk_lock.sv
module fault_brk_lock
  import brk_lock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h018
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [NUM_SRC-1:0] fault_i,
  output logic               brk_o,
  output logic               pvm_lock_o
);
  logic [NUM_SRC-1:0] lock_q;

  brk_lock_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .lock_o  (lock_q)
  );

  brk_lock_rd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_rd (
    .addr_i  (reg_addr_i),
    .lock_i  (lock_q),
    .rdata_o (reg_rdata_o)
  );

  brk_fault_merge u_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (fault_i),
    .lock_i  (lock_q),
    .brk_o   (brk_o)
  );

  assign pvm_lock_o = lock_q[PVM_IDX];
endmodule

// File: rtl/brk_lock_chk.sv
module brk_lock_chk
  import brk_lock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h018
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic [NUM_SRC-1:0] fault_i,
  input logic [NUM_SRC-1:0] lock_q,
  input logic               brk_o,
  input logic               pvm_lock_o
);
  localparam logic [31:0] MASK32 = wr_mask();
  localparam logic [DATA_W-1:0] MASK = DATA_W'(MASK32);

  logic [NUM_SRC-1:0] wr_sel;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    assign wr_sel[i] = reg_we_i && (reg_addr_i == REG_OFS) && reg_wdata_i[src_pos(i)];
  end

  // R4
  sticky_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q != '0) |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  // R3
  set_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel != '0) |=> ((lock_q & $past(wr_sel)) == $past(wr_sel)));

  // R6
  no_stray_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lock_q & ~$past(lock_q) & ~$past(wr_sel)) == '0));

  // R5
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~MASK) == '0);

  // R7
  brk_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fault_i & lock_q) != '0) |=> brk_o);

  // R8
  brk_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fault_i & lock_q) == '0) |=> !brk_o);

  // R9
  pvm_lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pvm_lock_o) |-> $past(wr_sel[PVM_IDX]));
endmodule

bind fault_brk_lock brk_lock_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .fault_i     (fault_i),
  .lock_q      (lock_q),
  .brk_o       (brk_o),
  .pvm_lock_o  (pvm_lock_o)
);

// File: tb/tb_fault_brk_lock.sv
module tb_fault_brk_lock;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam logic [AW-1:0] OFS = 12'h018;
  localparam logic [31:0] MASK = 32'h0000_FECC;
  localparam int POS [11] = '{15, 14, 13, 12, 11, 10, 9, 7, 6, 3, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = OFS;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [10:0]   fault = '0;
  logic          brk, pvm_lock;

  fault_brk_lock #(.DATA_W(DW), .ADDR_W(AW), .REG_OFS(OFS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .fault_i(fault),
    .brk_o(brk), .pvm_lock_o(pvm_lock)
  );

  typedef struct {
    int          cyc;
    logic [31:0] rd;
    logic        brk;
    logic        pvm;
    string       tag;
  } exp_t;

  exp_t        q[$];
  exp_t        e;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] model_lock = '0;
  bit          done = 0;

  // monitor: compare expected items due at this falling edge
  always @(negedge clk) begin
    cyc++;
    while (q.size() > 0 && q[0].cyc == cyc) begin
      e = q.pop_front();
      checks++;
      if (reg_rdata !== e.rd || brk !== e.brk || pvm_lock !== e.pvm) begin
        errors++;
        $display("FAIL %s: rdata=%h exp %h brk=%b exp %b pvm=%b exp %b",
                 e.tag, reg_rdata, e.rd, brk, e.brk, pvm_lock, e.pvm);
      end
    end
  end

  // driver: apply one cycle of stimulus and push the expected result
  task automatic drive(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [10:0] f, input string tag);
    logic [31:0] nxt;
    logic        b;
    @(negedge clk); #1;
    reg_we = we; reg_addr = a; reg_wdata = d; fault = f;
    nxt = model_lock;
    if (we && a == OFS) nxt = nxt | (d & MASK);
    b = 1'b0;
    for (int i = 0; i < 11; i++) if (f[i] && model_lock[POS[i]]) b = 1'b1;
    q.push_back('{cyc + 1, (a == OFS) ? nxt : 32'h0, b, nxt[2], tag});
    model_lock = nxt;
  endtask

  task automatic direct(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    direct("R1 rdata in reset", reg_rdata, 32'h0);
    direct("R1 brk in reset", {31'h0, brk}, 32'h0);
    direct("R1 pvm in reset", {31'h0, pvm_lock}, 32'h0);
    #1 rst_n = 1'b1;

    drive(0, OFS, 32'h0, 11'h7FF, "R1 R7 faults with no enable");
    drive(1, OFS, 32'hFFFF_0133, 11'h000, "R5 reserved write");
    drive(1, 12'h01C, 32'hFFFF_FFFF, 11'h000, "R6 write other offset");
    drive(0, OFS, 32'h0, 11'h000, "R6 R10 readback after stray write");
    drive(1, OFS, 32'h0000_8008, 11'h000, "R3 set axi and flash");
    drive(0, OFS, 32'h0, 11'h001, "R7 enabled fault");
    drive(0, OFS, 32'h0, 11'h002, "R7 disabled fault");
    drive(1, OFS, 32'h0, 11'h200, "R4 write zero keeps bits");
    drive(0, OFS, 32'h0, 11'h000, "R8 break released");
    drive(0, OFS, 32'h0, 11'h000, "R8 break stays low");
    drive(1, OFS, 32'h0000_0004, 11'h000, "R9 voltage monitor lock");
    drive(0, 12'h020, 32'h0, 11'h000, "R6 read other offset");
    for (int i = 0; i < 11; i++) begin
      drive(1, OFS, 32'h1 << POS[i], 11'h000, "R2 R3 set one source");
      drive(0, OFS, 32'h0, 11'h1 << i, "R2 R7 route one source");
      drive(0, OFS, 32'h0, 11'h000, "R2 R8 drop one source");
    end
    drive(1, OFS, 32'h0, 11'h7FF, "R4 R10 all bits held");
    drive(0, OFS, 32'h0, 11'h000, "R8 final release");
    repeat (3) @(negedge clk);

    #1 rst_n = 1'b0;
    @(negedge clk);
    direct("R4 reset clears rdata", reg_rdata, 32'h0);
    direct("R4 reset clears pvm", {31'h0, pvm_lock}, 32'h0);
    direct("R1 reset clears brk", {31'h0, brk}, 32'h0);
    #1 rst_n = 1'b1;
    model_lock = '0;
    drive(0, OFS, 32'h0, 11'h7FF, "R4 R7 no enable after reset");
    drive(1, OFS, 32'h0000_0040, 11'h100, "R3 lockup set");
    drive(0, OFS, 32'h0, 11'h100, "R7 lockup routed");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule